// File: doc/BRIEF.md
# NIC Power and Reset Sequencer

This block brings a network controller out of power-off in a fixed order. It turns on the controller's rails and waits until every rail reports power-good. It then holds cold reset for 20 ms before releasing it. Next it runs an early PCIe reset window: PERST# stays asserted for 30 ms, is released for 20 ms, and is asserted again. After that the block hands PERST# over to an upstream PERST# input. Delays are counted in clock cycles, and one millisecond is a parameter.

Once the rails should be up, the block watches them. Three events make it drop straight to idle with every output deasserted and a sticky faulted flag set: a power-good loss, a low upstream-ok input, or a one-cycle test-fault bit. The sequence can start again in two ways. One is a rising edge of the software enable. The other works only while the faulted flag is set: the upstream PERST# goes from low to high, which lets the upstream side re-run power-up after a fault. Either restart clears the faulted flag. An 8-bit raw state code shows the current step.

Top module: `nic_pwr_seq`

## Requirements
- R1: `raw_state_o` carries the current step as idle=0x00, power-enable=0x01, wait-for-power-good=0x02, cold-reset hold=0x03, PERST hold=0x04, early PERST release=0x05, done=0x06. `idle_o` is high exactly when the code is 0x00.
- R2: While `rst_ni` is low and afterwards in idle: state 0x00, `pwr_en_o`, `cld_rst_no`, `perst_no` and `faulted_o` are all low, and `idle_o` is high.
- R3: A rising edge of `sw_en_i` (the current value high while the value at the previous edge was low) latches a pending start. From idle the block then enters 0x01 on the next edge. A steadily high `sw_en_i` starts nothing.
- R4: State 0x01 lasts one cycle and raises `pwr_en_o`. State 0x02 holds until every bit of `rail_pg_i` is high, then moves to 0x03 on the next edge.
- R5: State 0x03 lasts exactly 20·MS_CYCLES cycles. On leaving it, `cld_rst_no` goes high.
- R6: State 0x04 lasts 30·MS_CYCLES cycles and then releases `perst_no` (high). State 0x05 lasts 20·MS_CYCLES cycles and then reasserts `perst_no` (low) while entering 0x06.
- R7: In state 0x06, `perst_no` follows `up_perst_ni`, two clock edges later.
- R8: A missing power-good counts as a fault only in states 0x03 to 0x06. In 0x02 it only stalls.
- R9: In any state other than idle, a rail fault or `up_ok_i` low forces state 0x00 on the next edge. In that same edge `faulted_o` is set and all three drive outputs go low.
- R10: A pulse on `test_fault_wr_i` sets an internal test-fault bit that clears itself after one cycle. The bit forces the fault of R9, so idle is reached two edges after the write.
- R11: A low-to-high change of `up_perst_ni` (current high, previous edge low) latches a pending start only while `faulted_o` is high. Any accepted start clears `faulted_o`.
- R12: In idle, `up_ok_i` low has no effect: the state stays 0x00 and `faulted_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_en_i | input | 1 | Software enable; its rising edge starts a sequence |
| rail_pg_i | input | N_RAILS | Power-good of each rail |
| up_ok_i | input | 1 | Upstream domain healthy |
| up_perst_ni | input | 1 | Upstream PERST#, active low |
| test_fault_wr_i | input | 1 | Write strobe of the self-clearing test-fault bit |
| pwr_en_o | output | 1 | Rail enable |
| cld_rst_no | output | 1 | Cold reset, active low |
| perst_no | output | 1 | PCIe reset, active low |
| faulted_o | output | 1 | Sticky fault flag |
| idle_o | output | 1 | High in idle |
| raw_state_o | output | 8 | Raw step code |

## Verification
The bench walks every delay phase and checks the exact edge on which each phase ends. A timer that is off by one would show up as a cold reset or PERST# release one cycle early or late. In each of the four phases that monitor the rails, it injects each rail loss, upstream-ok low and the test-fault bit. A design that checked faults before power-good was first seen, or that left the resets released after a fault, would fail these checks. The bench also checks that a PERST# release is ignored while the block is not faulted, and that a steady-high enable does not restart the sequence. A design that restarted on levels instead of edges would leave idle in those cases.

// File: rtl/nps_pkg.sv
`timescale 1ns/1ps
package nps_pkg;
  typedef enum logic [7:0] {
    ST_IDLE        = 8'h00,
    ST_PWR_EN      = 8'h01,
    ST_PG_WAIT     = 8'h02,
    ST_CLD_HOLD    = 8'h03,
    ST_PERST_HOLD  = 8'h04,
    ST_PERST_PULSE = 8'h05,
    ST_DONE        = 8'h06
  } seq_st_e;

  typedef enum logic [1:0] {
    RS_IN_RST    = 2'd0,
    RS_CLD_OFF   = 2'd1,
    RS_PERST_OFF = 2'd2
  } rst_st_e;
endpackage

// File: rtl/nps_restart.sv
`timescale 1ns/1ps
module nps_restart (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_en_i,
  input  logic up_perst_ni,
  input  logic test_fault_wr_i,
  input  logic faulted_i,
  output logic restart_o,
  output logic up_perst_q_o,
  output logic test_fault_o
);
  logic sw_q, perst_q, test_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q    <= 1'b0;
      perst_q <= 1'b0;
      test_q  <= 1'b0;
    end else begin
      sw_q    <= sw_en_i;
      perst_q <= up_perst_ni;
      test_q  <= test_fault_wr_i;  // self-clearing: holds only the latest strobe
    end
  end

  assign restart_o    = (sw_en_i & ~sw_q) | (faulted_i & ~perst_q & up_perst_ni);
  assign up_perst_q_o = perst_q;
  assign test_fault_o = test_q;

  // R10
  test_self_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_q && !test_fault_wr_i) |=> !test_fault_o);
endmodule

// File: rtl/nps_dly_timer.sv
`timescale 1ns/1ps
module nps_dly_timer #(
  parameter int CNT_W     = 32,
  parameter int MS_CYCLES = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic long_i,
  output logic done_o
);
  localparam logic [CNT_W-1:0] END_S = CNT_W'(20 * MS_CYCLES - 1);
  localparam logic [CNT_W-1:0] END_L = CNT_W'(30 * MS_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q == (long_i ? END_L : END_S));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= END_L);
endmodule

// File: rtl/nps_rst_ctrl.sv
`timescale 1ns/1ps
module nps_rst_ctrl
  import nps_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic cld_rel_i,
  input  logic perst_rel_i,
  input  logic perst_hold_i,
  input  logic follow_i,
  input  logic up_perst_i,
  output logic cld_rst_no,
  output logic perst_no
);
  rst_st_e rs_q, rs_d;

  always_comb begin
    rs_d = rs_q;
    if (hold_i) rs_d = RS_IN_RST;
    else begin
      case (rs_q)
        RS_IN_RST:    if (cld_rel_i) rs_d = RS_CLD_OFF;
        RS_CLD_OFF:   if (perst_rel_i || (follow_i && up_perst_i)) rs_d = RS_PERST_OFF;
        RS_PERST_OFF: if (perst_hold_i || (follow_i && !up_perst_i)) rs_d = RS_CLD_OFF;
        default:      rs_d = RS_IN_RST;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= RS_IN_RST;
    else         rs_q <= rs_d;
  end

  assign cld_rst_no = (rs_q != RS_IN_RST);
  assign perst_no   = (rs_q == RS_PERST_OFF);

  // R7
  perst_rel_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(perst_no) |-> $past(perst_rel_i || (follow_i && up_perst_i)));
endmodule

// File: rtl/nic_pwr_seq.sv
`timescale 1ns/1ps
module nic_pwr_seq
  import nps_pkg::*;
#(
  parameter int N_RAILS   = 3,
  parameter int MS_CYCLES = 50000,
  parameter int CNT_W     = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sw_en_i,
  input  logic [N_RAILS-1:0] rail_pg_i,
  input  logic               up_ok_i,
  input  logic               up_perst_ni,
  input  logic               test_fault_wr_i,
  output logic               pwr_en_o,
  output logic               cld_rst_no,
  output logic               perst_no,
  output logic               faulted_o,
  output logic               idle_o,
  output logic [7:0]         raw_state_o
);
  seq_st_e st_q, st_d;
  logic    pend_q, faulted_q;
  logic    restart, up_perst_q, test_fault, tmr_done;
  logic    pg_ok, rails_exp, fault_hit;

  nps_restart u_restart (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .sw_en_i         (sw_en_i),
    .up_perst_ni     (up_perst_ni),
    .test_fault_wr_i (test_fault_wr_i),
    .faulted_i       (faulted_q),
    .restart_o       (restart),
    .up_perst_q_o    (up_perst_q),
    .test_fault_o    (test_fault)
  );

  assign pg_ok     = &rail_pg_i;
  assign rails_exp = (st_q == ST_CLD_HOLD) || (st_q == ST_PERST_HOLD) ||
                     (st_q == ST_PERST_PULSE) || (st_q == ST_DONE);
  assign fault_hit = (st_q != ST_IDLE) &&
                     ((rails_exp && !pg_ok) || !up_ok_i || test_fault);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:        if (pend_q) st_d = ST_PWR_EN;
      ST_PWR_EN:      st_d = ST_PG_WAIT;
      ST_PG_WAIT:     if (pg_ok) st_d = ST_CLD_HOLD;
      ST_CLD_HOLD:    if (tmr_done) st_d = ST_PERST_HOLD;
      ST_PERST_HOLD:  if (tmr_done) st_d = ST_PERST_PULSE;
      ST_PERST_PULSE: if (tmr_done) st_d = ST_DONE;
      ST_DONE:        st_d = ST_DONE;
      default:        st_d = ST_IDLE;
    endcase
    if (fault_hit) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      pend_q    <= 1'b0;
      faulted_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (restart)                      pend_q <= 1'b1;
      else if (st_q == ST_IDLE)         pend_q <= 1'b0;
      // fault wins over a restart in the same cycle
      if (fault_hit)    faulted_q <= 1'b1;
      else if (restart) faulted_q <= 1'b0;
    end
  end

  nps_dly_timer #(
    .CNT_W     (CNT_W),
    .MS_CYCLES (MS_CYCLES)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st_d != st_q),
    .long_i (st_q == ST_PERST_HOLD),
    .done_o (tmr_done)
  );

  nps_rst_ctrl u_rst_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hold_i       (st_d == ST_IDLE),
    .cld_rel_i    ((st_q == ST_CLD_HOLD) && tmr_done),
    .perst_rel_i  ((st_q == ST_PERST_HOLD) && tmr_done),
    .perst_hold_i ((st_q == ST_PERST_PULSE) && tmr_done),
    .follow_i     (st_q == ST_DONE),
    .up_perst_i   (up_perst_q),
    .cld_rst_no   (cld_rst_no),
    .perst_no     (perst_no)
  );

  assign pwr_en_o    = (st_q != ST_IDLE);
  assign faulted_o   = faulted_q;
  assign idle_o      = (st_q == ST_IDLE);
  assign raw_state_o = st_q;

  // R1
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_state_o <= 8'h06);
  // R2
  off_in_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_o |-> (!cld_rst_no && !perst_no));
  // R3
  idle_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PWR_EN) |-> ($past(st_q) == ST_IDLE));
  // R9
  fault_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q != ST_IDLE) && !up_ok_i) |=> (idle_o && faulted_o));
  // R11
  restart_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart && (st_q == ST_IDLE)) |=> !faulted_o);
endmodule

// File: tb/nic_pwr_seq_bench.sv
`timescale 1ns/1ps
module nic_pwr_seq_bench;
  localparam int NR  = 3;
  localparam int MS  = 2;
  localparam int L20 = 20 * MS;
  localparam int L30 = 30 * MS;

  logic clk = 1'b0;
  logic rst_n, sw_en, up_ok, up_perst, test_wr;
  logic [NR-1:0] pg;
  logic pwr_en, cld_n, perst_n, faulted, idle;
  logic [7:0] raw;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  nic_pwr_seq #(.N_RAILS(NR), .MS_CYCLES(MS)) u_nic_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .sw_en_i(sw_en), .rail_pg_i(pg),
    .up_ok_i(up_ok), .up_perst_ni(up_perst), .test_fault_wr_i(test_wr),
    .pwr_en_o(pwr_en), .cld_rst_no(cld_n), .perst_no(perst_n),
    .faulted_o(faulted), .idle_o(idle), .raw_state_o(raw)
  );

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_off(input string req);
    chk({req, " state"}, raw, 0);
    chk({req, " idle"}, idle, 1);
    chk({req, " faulted"}, faulted, 1);
    chk({req, " drives"}, {pwr_en, cld_n, perst_n}, 0);
  endtask

  // start from idle via enable edge, stop once code == stop_st
  task automatic walk(input int stop_st);
    sw_en = 0; tick();
    sw_en = 1; tick();
    chk("R11 start clears flag", faulted, 0);
    chk("R3 pending only", raw, 0);
    tick();
    chk("R3 enter pwr_en", raw, 1);
    chk("R4 pwr_en_o", pwr_en, 1);
    tick();
    chk("R4 pg wait", raw, 2);
    if (stop_st == 2) return;
    tick();
    chk("R4 pgs seen", raw, 3);
    if (stop_st == 3) return;
    repeat (L20 - 1) tick();
    chk("R5 hold end", {raw, 7'd0, cld_n}, {8'd3, 8'd0});
    tick();
    chk("R5 cold released", {raw, 6'd0, cld_n, perst_n}, {8'd4, 8'd2});
    if (stop_st == 4) return;
    repeat (L30 - 1) tick();
    chk("R6 perst hold end", {raw, 7'd0, perst_n}, {8'd4, 8'd0});
    tick();
    chk("R6 perst released", {raw, 7'd0, perst_n}, {8'd5, 8'd1});
    if (stop_st == 5) return;
    repeat (L20 - 1) tick();
    chk("R6 release end", {raw, 7'd0, perst_n}, {8'd5, 8'd1});
    tick();
    chk("R6 perst reasserted", {raw, 7'd0, perst_n}, {8'd6, 8'd0});
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; sw_en = 0; pg = '1; up_ok = 1; up_perst = 0; test_wr = 0;
    repeat (3) tick();
    chk("R2 in reset", {raw, 3'd0, pwr_en, cld_n, perst_n, faulted, idle}, {8'd0, 8'd1});
    rst_n = 1; tick();
    chk("R2 after reset", {raw, 3'd0, pwr_en, cld_n, perst_n, faulted, idle}, {8'd0, 8'd1});

    up_ok = 0; repeat (3) tick();
    chk("R12 up_ok low idle", {raw, 7'd0, faulted}, 0);
    up_ok = 1;
    up_perst = 1; repeat (3) tick();
    chk("R11 perst edge ignored unfaulted", {raw, 7'd0, faulted}, 0);
    up_perst = 0; tick();

    // R8: missing power-good only stalls
    pg = 3'b110;
    walk(2);
    repeat (5) tick();
    chk("R8 stall no fault", {raw, 7'd0, faulted}, {8'd2, 8'd0});
    pg = '1; tick();
    chk("R8 proceed", raw, 3);
    up_ok = 0; tick();
    chk_off("R9 up_ok");
    up_ok = 1;

    // R7 follow, R10 test bit, R11 perst restart
    walk(6);
    up_perst = 1; tick();
    chk("R7 lag 1", perst_n, 0);
    tick();
    chk("R7 follow high", perst_n, 1);
    up_perst = 0; tick();
    chk("R7 lag 1 low", perst_n, 1);
    tick();
    chk("R7 follow low", perst_n, 0);
    test_wr = 1; tick(); test_wr = 0;
    chk("R10 one edge later", raw, 6);
    tick();
    chk_off("R10 test fault");
    repeat (4) tick();
    chk("R3 level no restart", {raw, 7'd0, faulted}, {8'd0, 8'd1});
    up_perst = 1; tick();
    chk("R11 perst restart clears", {raw, 7'd0, faulted}, 0);
    tick();
    chk("R11 perst restart runs", raw, 1);
    up_ok = 0; tick();
    chk_off("R9 up_ok pwr_en");
    up_ok = 1; up_perst = 0; tick();

    // sweep fault source x monitored phase
    for (int st = 3; st <= 6; st++) begin
      for (int src = 0; src <= 4; src++) begin
        walk(st);
        if (src < NR) begin
          pg[src] = 1'b0; tick(); pg = '1;
          chk_off("R9 rail");
        end else if (src == NR) begin
          up_ok = 0; tick(); up_ok = 1;
          chk_off("R9 up_ok");
        end else begin
          test_wr = 1; tick(); test_wr = 0;
          chk("R10 bit delay", raw, st);
          tick();
          chk_off("R10 sweep");
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule